// File: doc/BRIEF.md
# Mailbox Boot Loader Sequencer

This block fills the core's program RAM from a host processor after reset. The host sends the image through the same mailbox data registers it uses for normal message passing. The loader watches the stream of mailbox write events, each carrying a register index and a 16-bit value. It turns each group of three byte writes into one 24-bit instruction word and writes that word to a program RAM port. Words are stored from the top of the image down to address 0. When the last word is written, the block raises a one-cycle done pulse that releases the core, and it then goes back to idle.

A sequence starts only after a hardware reset or a soft reset, and only when the memory-map strap is low and the boot-source select is high. Otherwise the loader stays idle and leaves the mailbox traffic alone. The first host write gives the image length in blocks of eight words. After that, every instruction arrives as an upper byte, then a lower byte, then a middle byte. Writes to an unexpected register are dropped and recorded in a sticky error flag.

Top module: `mbox_boot_loader`

## Requirements
- R1: During and right after a reset, `boot_active`, `pm_we`, `boot_done` and `seq_err` are all 0. While the block is idle, mailbox writes produce no program RAM write.
- R2: A load sequence starts on the first clock after a hardware reset or soft reset is released, but only if `strap_map` is 0 and `boot_sel` is 1 on that clock. From the following cycle, `boot_active` is 1.
- R3: The first accepted write must use index 3. Its low byte gives the length value L, and exactly 8 × (L + 1) words are then loaded. For example, L = 0 loads 8 words and L = 124 loads 1000 words.
- R4: Each word takes three writes: index 0 carries the upper byte, index 2 the lower byte and index 1 the middle byte. The stored word is {upper, middle, lower}.
- R5: The first word goes to address 8 × (L + 1) − 1. Each later word goes to the address one below the previous word, and the last word goes to address 0.
- R6: Bits 15:8 of the mailbox data have no effect on the stored words or on the length.
- R7: `pm_we` is high for exactly one cycle, on the cycle after the middle-byte write is accepted.
- R8: The loader accepts mailbox writes on every clock, with no idle cycles required between them.
- R9: `boot_done` pulses for one cycle, on the cycle after the write to address 0. `boot_active` is 1 through that final write cycle and 0 from the done cycle onward. Once done, the block is idle and ignores further writes.
- R10: A write whose index does not match the expected one is ignored and sets `seq_err`. `seq_err` stays set until the next hardware or soft reset.
- R11: `soft_rst` abandons any partly loaded sequence. It clears `seq_err`, and it restarts the loader under the R2 conditions.
- R12: When `strap_map` is 1 or `boot_sel` is 0 at the start point, no sequence starts. Length and byte writes then give no `pm_we` and leave `boot_active` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| strap_map | input | 1 | Memory-map strap; 0 allows loading |
| boot_sel | input | 1 | Boot source; 1 selects the host mailbox |
| mb_wr_valid | input | 1 | A host mailbox write occurs this cycle |
| mb_wr_idx | input | 3 | Index of the mailbox register being written |
| mb_wr_data | input | 16 | Write data; only bits 7:0 are used |
| pm_addr | output | PM_ADDR_W (11) | Program RAM write address |
| pm_wdata | output | 24 | Program RAM write data |
| pm_we | output | 1 | Program RAM write enable |
| boot_active | output | 1 | A load sequence is in progress |
| boot_done | output | 1 | One-cycle pulse when loading finishes |
| seq_err | output | 1 | Sticky flag: a write arrived out of order |

## Verification
The hardest case to reach from the ports is a soft reset that lands in the middle of a word. At that point, byte registers already hold partial data and the address counter is already loaded. A stray write here would put a corrupt word into RAM. The stimulus sends a length and two of a word's three bytes, pulses `soft_rst`, and then runs a complete new image. The scoreboard must see only the new image's words, with no leftover write. Out-of-order writes are injected both before the length and between bytes of a word, to show that the dropped write does not disturb the sequence.

// File: rtl/mbl_pkg.sv
package mbl_pkg;

  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_HI,
    ST_LO,
    ST_MID
  } ld_state_e;

  // Mailbox indices the sequence expects, in the order the host sends them
  localparam logic [2:0] IDX_LEN    = 3'd3;
  localparam logic [2:0] IDX_UPPER  = 3'd0;
  localparam logic [2:0] IDX_LOWER  = 3'd2;
  localparam logic [2:0] IDX_MIDDLE = 3'd1;

  // Index that is legal in a given state
  function automatic logic [2:0] expected_idx(input ld_state_e st);
    case (st)
      ST_LEN:  return IDX_LEN;
      ST_HI:   return IDX_UPPER;
      ST_LO:   return IDX_LOWER;
      ST_MID:  return IDX_MIDDLE;
      default: return IDX_LEN;
    endcase
  endfunction

  // Instruction word layout: upper byte on top, middle, then lower
  function automatic logic [WORD_W-1:0] pack_word(input logic [BYTE_W-1:0] up,
                                                  input logic [BYTE_W-1:0] mid,
                                                  input logic [BYTE_W-1:0] lo);
    return {up, mid, lo};
  endfunction

endpackage

// File: rtl/mbl_start_ctl.sv
module mbl_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic strap_map,
  input  logic boot_sel,
  output logic clr,
  output logic start
);

  logic arm_q;

  // Armed for exactly one evaluation after any reset is released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b1;
    else        arm_q <= soft_rst;
  end

  assign clr   = soft_rst;
  assign start = arm_q & ~soft_rst & ~strap_map & boot_sel;

  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R2

endmodule

// File: rtl/mbl_byte_asm.sv
module mbl_byte_asm
  import mbl_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              wr_valid,
  input  logic [2:0]        wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              addr_last,
  output logic              len_load,
  output logic [LEN_W-1:0]  len_val,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              seq_err
);

  ld_state_e         state_q, state_d;
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              err_q;
  logic              hit, bad;

  assign hit = wr_valid & ~clr & (state_q != ST_IDLE) & (wr_idx == expected_idx(state_q));
  assign bad = wr_valid & ~clr & (state_q != ST_IDLE) & (wr_idx != expected_idx(state_q));

  always_comb begin
    state_d   = state_q;
    len_load  = 1'b0;
    word_done = 1'b0;
    case (state_q)
      ST_LEN: if (hit) begin
        len_load = 1'b1;
        state_d  = ST_HI;
      end
      ST_HI:  if (hit) state_d = ST_LO;
      ST_LO:  if (hit) state_d = ST_MID;
      ST_MID: if (hit) begin
        word_done = 1'b1;
        state_d   = addr_last ? ST_IDLE : ST_HI;
      end
      default: if (start) state_d = ST_LEN;
    endcase
    if (clr) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hi_q    <= '0;
      lo_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hit && state_q == ST_HI) hi_q <= wr_byte;
      if (hit && state_q == ST_LO) lo_q <= wr_byte;
      if (clr)      err_q <= 1'b0;
      else if (bad) err_q <= 1'b1;
    end
  end

  assign len_val = wr_byte[LEN_W-1:0];
  assign word    = pack_word(hi_q, wr_byte, lo_q);
  assign busy    = (state_q != ST_IDLE);
  assign seq_err = err_q;

  AST_BAD_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> state_q == $past(state_q)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err && !clr |=> seq_err); // R10

endmodule

// File: rtl/mbl_addr_ctr.sv
module mbl_addr_ctr #(
  parameter int PM_ADDR_W = 11,
  localparam int LEN_W = PM_ADDR_W - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 len_load,
  input  logic [LEN_W-1:0]     len_val,
  input  logic                 word_done,
  output logic [PM_ADDR_W-1:0] addr,
  output logic                 is_last
);

  // Top address of an image of 8*(len+1) words
  function automatic logic [PM_ADDR_W-1:0] top_of(input logic [LEN_W-1:0] len);
    return {len, 3'b111};
  endfunction

  logic [PM_ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (clr)       addr_q <= '0;
    else if (len_load)  addr_q <= top_of(len_val);
    else if (word_done) addr_q <= addr_q - 1'b1;
  end

  assign addr    = addr_q;
  assign is_last = (addr_q == '0);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !is_last && !clr |=> addr == $past(addr) - 1'b1); // R5

endmodule

// File: rtl/mbl_pm_wr.sv
module mbl_pm_wr
  import mbl_pkg::*;
#(
  parameter int PM_ADDR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 word_done,
  input  logic [PM_ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]    word,
  input  logic                 is_last,
  output logic                 pm_we,
  output logic [PM_ADDR_W-1:0] pm_addr,
  output logic [WORD_W-1:0]    pm_wdata,
  output logic                 done
);

  logic                 we_q, last_q, done_q;
  logic [PM_ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= word_done & ~clr;
      last_q <= word_done & is_last & ~clr;
      done_q <= we_q & last_q & ~clr;
      if (word_done) begin
        addr_q <= addr;
        data_q <= word;
      end
    end
  end

  assign pm_we    = we_q;
  assign pm_addr  = addr_q;
  assign pm_wdata = data_q;
  assign done     = done_q;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |=> !pm_we); // R7
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pm_we) && ($past(pm_addr) == '0)); // R9

endmodule

// File: rtl/mbox_boot_loader.sv
module mbox_boot_loader
  import mbl_pkg::*;
#(
  parameter int PM_ADDR_W = 11,
  parameter int MB_DATA_W = 16,
  localparam int LEN_W = PM_ADDR_W - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 strap_map,
  input  logic                 boot_sel,
  input  logic                 mb_wr_valid,
  input  logic [2:0]           mb_wr_idx,
  input  logic [MB_DATA_W-1:0] mb_wr_data,
  output logic [PM_ADDR_W-1:0] pm_addr,
  output logic [WORD_W-1:0]    pm_wdata,
  output logic                 pm_we,
  output logic                 boot_active,
  output logic                 boot_done,
  output logic                 seq_err
);

  // Internal events, named for the assertions
  logic                 clr, start;
  logic                 len_load, word_done, busy, is_last;
  logic [LEN_W-1:0]     len_val;
  logic [WORD_W-1:0]    word;
  logic [PM_ADDR_W-1:0] cur_addr;
  logic                 unused_upper;

  // Only the low byte of each mailbox write is meaningful
  assign unused_upper = ^mb_wr_data[MB_DATA_W-1:BYTE_W];

  mbl_start_ctl u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .strap_map (strap_map),
    .boot_sel  (boot_sel),
    .clr       (clr),
    .start     (start)
  );

  mbl_byte_asm #(.LEN_W(LEN_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .start     (start),
    .wr_valid  (mb_wr_valid),
    .wr_idx    (mb_wr_idx),
    .wr_byte   (mb_wr_data[BYTE_W-1:0]),
    .addr_last (is_last),
    .len_load  (len_load),
    .len_val   (len_val),
    .word_done (word_done),
    .word      (word),
    .busy      (busy),
    .seq_err   (seq_err)
  );

  mbl_addr_ctr #(.PM_ADDR_W(PM_ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .len_load  (len_load),
    .len_val   (len_val),
    .word_done (word_done),
    .addr      (cur_addr),
    .is_last   (is_last)
  );

  mbl_pm_wr #(.PM_ADDR_W(PM_ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .word_done (word_done),
    .addr      (cur_addr),
    .word      (word),
    .is_last   (is_last),
    .pm_we     (pm_we),
    .pm_addr   (pm_addr),
    .pm_wdata  (pm_wdata),
    .done      (boot_done)
  );

  assign boot_active = busy | pm_we;

  AST_WE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> boot_active); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done && !boot_active); // R9

endmodule

// File: tb/test_mbox_boot_loader.sv
module test_mbox_boot_loader;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          strap_map = 1'b0;
  logic          boot_sel = 1'b1;
  logic          mb_wr_valid = 1'b0;
  logic [2:0]    mb_wr_idx = '0;
  logic [15:0]   mb_wr_data = '0;
  logic [AW-1:0] pm_addr;
  logic [23:0]   pm_wdata;
  logic          pm_we, boot_active, boot_done, seq_err;

  mbox_boot_loader i_mbox_boot_loader (
    .clk, .rst_n, .soft_rst, .strap_map, .boot_sel,
    .mb_wr_valid, .mb_wr_idx, .mb_wr_data,
    .pm_addr, .pm_wdata, .pm_we, .boot_active, .boot_done, .seq_err
  );

  always #2 clk = ~clk;   // 250 MHz

  typedef struct packed {
    logic [AW-1:0] a;
    logic [23:0]   d;
    logic [31:0]   c;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0, cyc = 0;
  int   words_seen = 0, dones_seen = 0, last_we_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pm_we) begin
        words_seen++;
        last_we_cyc = cyc;
        if (exp_q.size() == 0) begin
          chk(0, "R12", "unexpected pm_we addr", pm_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(pm_addr == e.a, "R5", "pm_addr", pm_addr, e.a);
          chk(pm_wdata == e.d, "R4", "pm_wdata", pm_wdata, e.d);
          chk(cyc == int'(e.c), "R7", "pm_we cycle", cyc, e.c);
          chk(boot_active, "R9", "active during write", boot_active, 1);
        end
      end
      if (boot_done) begin
        dones_seen++;
        chk(cyc == last_we_cyc + 1, "R9", "done cycle", cyc, last_we_cyc + 1);
        chk(!boot_active, "R9", "active on done", boot_active, 0);
      end
    end
  end

  // Drive one mailbox write; caller is 1 time unit past a rising edge
  task automatic host_wr(input logic [2:0] idx, input logic [15:0] data);
    mb_wr_valid = 1'b1;
    mb_wr_idx   = idx;
    mb_wr_data  = data;
    @(posedge clk); #1;
  endtask

  task automatic host_idle(input int n);
    mb_wr_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic hw_reset(input logic strap, input logic sel);
    rst_n = 1'b0;
    exp_q.delete();
    strap_map = strap;
    boot_sel  = sel;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(!boot_active && !pm_we && !boot_done && !seq_err, "R1", "reset outputs",
        {boot_active, pm_we, boot_done, seq_err}, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic pulse_soft;
    soft_rst = 1'b1;
    mb_wr_valid = 1'b0;
    @(posedge clk); #1;
    soft_rst = 1'b0;
    exp_q.delete();
    @(posedge clk); #1;
  endtask

  function automatic logic [23:0] pattern(input int addr, input int seed);
    return 24'((addr * 40503 + seed * 7919) ^ (addr << 13));
  endfunction

  // Full image, back-to-back writes, upper data byte set to fill
  task automatic boot_image(input int len, input int seed, input logic [7:0] fill);
    int   top;
    exp_t e;
    top = 8 * (len + 1) - 1;
    host_wr(3'd3, {fill, 8'(len)});
    for (int a = top; a >= 0; a--) begin
      logic [23:0] w;
      w = pattern(a, seed);
      host_wr(3'd0, {fill, w[23:16]});
      host_wr(3'd2, {fill, w[7:0]});
      e.a = AW'(a);
      e.d = w;
      e.c = 32'(cyc + 1);
      exp_q.push_back(e);
      host_wr(3'd1, {fill, w[15:8]});
    end
    host_idle(4);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected <150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int ws, ds;

    // R12 / R1: strap high keeps the loader idle
    hw_reset(1'b1, 1'b1);
    chk(!boot_active, "R12", "idle with strap set", boot_active, 0);
    host_wr(3'd3, 16'h0000);
    host_wr(3'd0, 16'h0011);
    host_wr(3'd2, 16'h0022);
    host_wr(3'd1, 16'h0033);
    host_idle(3);
    chk(!boot_active && words_seen == 0, "R1", "writes ignored idle",
        words_seen, 0);

    // R12: host boot source not selected
    hw_reset(1'b0, 1'b0);
    host_wr(3'd3, 16'h0000);
    host_idle(2);
    chk(!boot_active, "R12", "idle with boot_sel=0", boot_active, 0);

    // R2, R3, R4, R5, R7, R8: eight-word image
    hw_reset(1'b0, 1'b1);
    chk(boot_active, "R2", "active after reset", boot_active, 1);
    ws = words_seen; ds = dones_seen;
    boot_image(0, 1, 8'h00);
    chk(words_seen - ws == 8, "R3", "word count L=0", words_seen - ws, 8);
    chk(dones_seen - ds == 1, "R9", "done pulses", dones_seen - ds, 1);
    chk(exp_q.size() == 0, "R8", "all writes accepted", exp_q.size(), 0);
    // R9: idle after done, new writes ignored
    ws = words_seen;
    host_wr(3'd3, 16'h0000);
    host_wr(3'd0, 16'h0001);
    host_wr(3'd2, 16'h0002);
    host_wr(3'd1, 16'h0003);
    host_idle(3);
    chk(!boot_active && words_seen == ws, "R9", "ignored after done",
        words_seen - ws, 0);

    // R11 + R6: soft reset restarts; upper byte junk has no effect
    pulse_soft();
    chk(boot_active, "R11", "soft reset restarts", boot_active, 1);
    ws = words_seen;
    boot_image(1, 2, 8'hA5);
    chk(words_seen - ws == 16, "R6", "word count L=1 with junk", words_seen - ws, 16);

    // R10: wrong index before length, and between bytes
    pulse_soft();
    host_wr(3'd0, 16'h0077);
    chk(seq_err, "R10", "error on wrong first index", seq_err, 1);
    chk(boot_active, "R10", "still waiting for length", boot_active, 1);
    begin
      exp_t e;
      host_wr(3'd3, 16'h0000);
      for (int a = 7; a >= 0; a--) begin
        logic [23:0] w;
        w = pattern(a, 3);
        host_wr(3'd0, {8'h00, w[23:16]});
        if (a == 5) host_wr(3'd4, 16'h00EE);   // stray write, must be dropped
        host_wr(3'd2, {8'h00, w[7:0]});
        e.a = AW'(a); e.d = w; e.c = 32'(cyc + 1);
        exp_q.push_back(e);
        host_wr(3'd1, {8'h00, w[15:8]});
      end
      host_idle(4);
    end
    chk(seq_err, "R10", "error stays set", seq_err, 1);
    chk(exp_q.size() == 0, "R10", "sequence unharmed", exp_q.size(), 0);
    pulse_soft();
    chk(!seq_err, "R11", "soft reset clears error", seq_err, 0);

    // R11: abort in the middle of a word
    ws = words_seen;
    host_wr(3'd3, 16'h0001);
    host_wr(3'd0, 16'h00C1);
    host_wr(3'd2, 16'h00C2);
    pulse_soft();
    chk(words_seen == ws, "R11", "no write from aborted word", words_seen - ws, 0);
    boot_image(0, 4, 8'h00);
    chk(words_seen - ws == 8, "R11", "clean image after abort", words_seen - ws, 8);

    // R3, R5: 1000-word image, length 124
    pulse_soft();
    ws = words_seen;
    boot_image(124, 5, 8'h00);
    chk(words_seen - ws == 1000, "R3", "word count L=124", words_seen - ws, 1000);
    chk(!boot_active, "R9", "idle at end", boot_active, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule